// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block gathers interrupt requests for a USB controller bridge into one interrupt line for a host processor. Two secondary groups of 32 pending bits, one for the USB core and one for DMA completion, each have a set, clear and mask register reachable over a simple synchronous 32-bit register port. Each group folds its unmasked pending bits into dedicated summary bits of a 32-bit top-level pending register. The USB core group is split so its lower half (transmit) and upper half (receive) raise separate summary bits.

The top level has its own set, clear and mask registers. Level-type hardware events can load any non-summary top-level bit directly, and a change on the VBUS-valid input latches a dedicated top-level bit. One registered interrupt output is produced, and a configuration bit chooses its meaning: high when some unmasked top-level bit is pending, or high when none is. All register writes take effect at the next clock edge. Reads return data one cycle after the read strobe.

Top module: `intc_hier_top`

## Requirements
- R1: After reset the top-level mask and both group masks read 0xFFFFFFFF, all pending registers and the control config read 0, and `irq_o` is 1.
- R2: A write to a SET address (group base +0x4) ORs the written data into that register's pending bits. A write to a CLEAR address (base +0x8) clears each pending bit where the data has a 1. The group bases are 0x840 (USB core), 0x850 (DMA) and 0x870 (top level).
- R3: A read of the source (base +0x0), set or clear address of a group returns that group's current pending value. A read of base +0xC returns its mask. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R4: Top-level bit 9 is 1 exactly when the USB core group has an unmasked pending bit in bits 15:0. Top-level bit 8 is 1 exactly when it has one in bits 31:16.
- R5: Top-level bit 24 is 1 exactly when the DMA group has any unmasked pending bit.
- R6: Top-level bits 8, 9 and 24 are not changed by top-level set or clear writes, nor by hardware events.
- R7: With control config (0x83C) bit 17 equal to 1, `irq_o` is high when (top pending AND NOT top mask) is nonzero. With bit 17 equal to 0, `irq_o` is high only when that value is zero.
- R8: `irq_o` is registered. It reflects a register write one clock edge after the edge that performs the write.
- R9: An event (`ev_valid`=1) loads `ev_level` into top-level bit `ev_idx` at the next edge. The same edge also applies any bus write, and the event takes priority.
- R10: Any change of `vbus_valid` between consecutive clock edges sets top-level bit 15. This takes priority over a clear in the same cycle. While `vbus_valid` is steady, bit 15 is not set again.
- R11: The control config register is read/write over all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ev_valid | input | 1 | Hardware event strobe |
| ev_idx | input | 5 | Top-level bit targeted by the event |
| ev_level | input | 1 | Level loaded into the targeted bit |
| vbus_valid | input | 1 | VBUS-valid level; changes are latched |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A corrupted group pending or mask register shows up in two places. It appears in that group's readback, and it appears in the derived summary bits of the top-level pending read, one cycle after the read strobe. A wrong polarity or a stale mask shows up on `irq_o` exactly one edge after the write that should have moved it. The bench therefore samples the line both before and after that edge. A summary bit that set or clear writes can corrupt, or an edge detector that retriggers, appears in the very next top-level readback.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int NUM_GRP  = 2;

  // register offsets; software decodes these
  localparam logic [ADDR_W-1:0] CFG_ADDR  = 12'h83C;
  localparam logic [ADDR_W-1:0] USB_BASE  = 12'h840;
  localparam logic [ADDR_W-1:0] DMA_BASE  = 12'h850;
  localparam logic [ADDR_W-1:0] TOP_BASE  = 12'h870;

  // slot within a group window
  typedef enum logic [1:0] {
    SLOT_SRC  = 2'd0,
    SLOT_SET  = 2'd1,
    SLOT_CLR  = 2'd2,
    SLOT_MASK = 2'd3
  } slot_e;

  localparam int POL_BIT  = 17;
  localparam int TX_BIT   = 9;
  localparam int RX_BIT   = 8;
  localparam int DMA_BIT  = 24;
  localparam int VBUS_BIT = 15;

  function automatic logic [ADDR_W-1:0] grp_base(input int gi);
    return (gi == 0) ? USB_BASE : DMA_BASE;
  endfunction
endpackage

// File: rtl/intc_group.sv
module intc_group #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_mask,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] pend,
  output logic [WIDTH-1:0] mask
);
  logic [WIDTH-1:0] set_v, clr_v;

  always_comb begin
    set_v = wr_set ? wdata : '0;
    clr_v = wr_clr ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      mask <= '1;
    end else begin
      pend <= (pend | set_v) & ~clr_v;
      if (wr_mask) mask <= wdata;
    end
  end
endmodule

// File: rtl/intc_toplvl.sv
module intc_toplvl #(
  parameter int WIDTH    = 32,
  parameter int TX_BIT   = 9,
  parameter int RX_BIT   = 8,
  parameter int DMA_BIT  = 24,
  parameter int VBUS_BIT = 15,
  localparam int IDX_W   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_mask,
  input  logic [WIDTH-1:0] wdata,
  input  logic             sum_tx,
  input  logic             sum_rx,
  input  logic             sum_dma,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             ev_level,
  input  logic             vbus_chg,
  output logic [WIDTH-1:0] pend,
  output logic [WIDTH-1:0] mask
);
  localparam logic [WIDTH-1:0] DERIV_MSK =
    (WIDTH'(1) << TX_BIT) | (WIDTH'(1) << RX_BIT) | (WIDTH'(1) << DMA_BIT);

  logic [WIDTH-1:0] stored_q, stored_d, deriv;

  always_comb begin
    stored_d = stored_q;
    if (wr_set) stored_d = stored_d | wdata;
    if (wr_clr) stored_d = stored_d & ~wdata;
    if (ev_valid) stored_d[ev_idx] = ev_level;
    if (vbus_chg) stored_d[VBUS_BIT] = 1'b1;
    stored_d = stored_d & ~DERIV_MSK;
  end

  always_comb begin
    deriv = '0;
    deriv[TX_BIT]  = sum_tx;
    deriv[RX_BIT]  = sum_rx;
    deriv[DMA_BIT] = sum_dma;
    pend = stored_q | deriv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stored_q <= '0;
      mask     <= '1;
    end else begin
      stored_q <= stored_d;
      if (wr_mask) mask <= wdata;
    end
  end
endmodule

// File: rtl/intc_irq_out.sv
module intc_irq_out #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pend,
  input  logic [WIDTH-1:0] mask,
  input  logic             active_high,
  output logic             irq_o
);
  logic any_live;
  assign any_live = |(pend & ~mask);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b1;
    else     irq_o <= active_high ? any_live : ~any_live;
  end
endmodule

// File: rtl/intc_hier_top.sv
module intc_hier_top
  import intc_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  localparam int IDXW = $clog2(DW),
  localparam int HALF = DW / 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            ev_valid,
  input  logic [IDXW-1:0] ev_idx,
  input  logic            ev_level,
  input  logic            vbus_valid,
  output logic            irq_o
);
  logic [DW-1:0] grp_pend [NUM_GRP];
  logic [DW-1:0] grp_mask [NUM_GRP];
  logic [DW-1:0] top_pend, top_mask, cfg_q, rd_mux;
  logic          vbus_q, vbus_chg;
  logic          sum_tx, sum_rx, sum_dma;

  function automatic logic hit(input logic [AW-1:0] a, input logic [AW-1:0] base,
                               input slot_e s);
    return a == (base + AW'({s, 2'b00}));
  endfunction

  // secondary groups
  for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_grp
    localparam logic [AW-1:0] BASE = grp_base(gi);
    intc_group #(.WIDTH(DW)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .wr_set (bus_wr && hit(bus_addr, BASE, SLOT_SET)),
      .wr_clr (bus_wr && hit(bus_addr, BASE, SLOT_CLR)),
      .wr_mask(bus_wr && hit(bus_addr, BASE, SLOT_MASK)),
      .wdata  (bus_wdata),
      .pend   (grp_pend[gi]),
      .mask   (grp_mask[gi])
    );
  end

  always_comb begin
    sum_tx  = |(grp_pend[0][HALF-1:0]  & ~grp_mask[0][HALF-1:0]);
    sum_rx  = |(grp_pend[0][DW-1:HALF] & ~grp_mask[0][DW-1:HALF]);
    sum_dma = |(grp_pend[1] & ~grp_mask[1]);
  end

  assign vbus_chg = vbus_valid ^ vbus_q;

  intc_toplvl #(
    .WIDTH(DW), .TX_BIT(TX_BIT), .RX_BIT(RX_BIT),
    .DMA_BIT(DMA_BIT), .VBUS_BIT(VBUS_BIT)
  ) u_top (
    .clk     (clk),
    .rst     (rst),
    .wr_set  (bus_wr && hit(bus_addr, TOP_BASE, SLOT_SET)),
    .wr_clr  (bus_wr && hit(bus_addr, TOP_BASE, SLOT_CLR)),
    .wr_mask (bus_wr && hit(bus_addr, TOP_BASE, SLOT_MASK)),
    .wdata   (bus_wdata),
    .sum_tx  (sum_tx),
    .sum_rx  (sum_rx),
    .sum_dma (sum_dma),
    .ev_valid(ev_valid),
    .ev_idx  (ev_idx),
    .ev_level(ev_level),
    .vbus_chg(vbus_chg),
    .pend    (top_pend),
    .mask    (top_mask)
  );

  intc_irq_out #(.WIDTH(DW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .pend       (top_pend),
    .mask       (top_mask),
    .active_high(cfg_q[POL_BIT]),
    .irq_o      (irq_o)
  );

  // read mux
  always_comb begin
    rd_mux = '0;
    if (bus_addr == CFG_ADDR) rd_mux = cfg_q;
    for (int gi = 0; gi < NUM_GRP; gi++) begin
      if (hit(bus_addr, grp_base(gi), SLOT_SRC) || hit(bus_addr, grp_base(gi), SLOT_SET) ||
          hit(bus_addr, grp_base(gi), SLOT_CLR))
        rd_mux = grp_pend[gi];
      if (hit(bus_addr, grp_base(gi), SLOT_MASK)) rd_mux = grp_mask[gi];
    end
    if (hit(bus_addr, TOP_BASE, SLOT_SRC) || hit(bus_addr, TOP_BASE, SLOT_SET) ||
        hit(bus_addr, TOP_BASE, SLOT_CLR))
      rd_mux = top_pend;
    if (hit(bus_addr, TOP_BASE, SLOT_MASK)) rd_mux = top_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      vbus_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      vbus_q <= vbus_valid;
      if (bus_wr && bus_addr == CFG_ADDR) cfg_q <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/intc_hier_chk.sv
module intc_hier_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] usb_pend,
  input logic [31:0] usb_mask,
  input logic [31:0] top_pend,
  input logic [31:0] top_mask,
  input logic [31:0] cfg_q,
  input logic        vbus_valid,
  input logic        irq_o
);
  // R1: output comes out of reset at its idle level
  assert_reset_irq_R1: assert property (@(posedge clk) $fell(rst) |-> irq_o);

  // R2: USB group set write ORs data into pending
  assert_usb_set_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr) && $past(bus_addr) == 12'h844 && !$past(usb_pend[0] && 1'b0))
    |-> usb_pend == ($past(usb_pend) | $past(bus_wdata)));

  // R2: USB group clear write removes bits
  assert_usb_clr_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr) && $past(bus_addr) == 12'h848)
    |-> usb_pend == ($past(usb_pend) & ~$past(bus_wdata)));

  // R4: TX summary follows the low half of the USB group
  assert_tx_summary_R4: assert property (@(posedge clk) disable iff (rst)
    top_pend[9] == |(usb_pend[15:0] & ~usb_mask[15:0]));

  // R7 / R8: registered output follows the previous cycle's state and polarity
  assert_irq_polarity_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_o == ($past(cfg_q[17]) ? |($past(top_pend) & ~$past(top_mask))
                                                : ~|($past(top_pend) & ~$past(top_mask))));

  // R10: a VBUS edge latches bit 15
  assert_vbus_latch_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(vbus_valid) != $past(vbus_valid, 2)) |-> top_pend[15]);
endmodule

bind intc_hier_top intc_hier_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .usb_pend  (grp_pend[0]),
  .usb_mask  (grp_mask[0]),
  .top_pend  (top_pend),
  .top_mask  (top_mask),
  .cfg_q     (cfg_q),
  .vbus_valid(vbus_valid),
  .irq_o     (irq_o)
);

// File: tb/test_intc_hier_top.sv
`timescale 1ns/1ps
module test_intc_hier_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_valid = 0, ev_level = 0, vbus_valid = 0;
  logic [4:0]  ev_idx = '0;
  logic        irq_o;
  int checks = 0, fails = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  intc_hier_top i_intc_hier_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_valid(ev_valid),
    .ev_idx(ev_idx), .ev_level(ev_level), .vbus_valid(vbus_valid), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq_o}, 32'd1);
    rd_chk("R1 top mask", 12'h87C, 32'hFFFF_FFFF);
    rd_chk("R1 usb mask", 12'h84C, 32'hFFFF_FFFF);
    rd_chk("R1 dma mask", 12'h85C, 32'hFFFF_FFFF);
    rd_chk("R1 top pend", 12'h870, 32'h0);
    rd_chk("R1 cfg", 12'h83C, 32'h0);
  endtask

  task automatic t_group;
    wr(12'h84C, 32'h0);
    wr(12'h844, 32'h0000_0005);
    rd_chk("R2 usb set", 12'h840, 32'h0000_0005);
    wr(12'h844, 32'h0001_0000);
    rd_chk("R3 read via clear addr", 12'h848, 32'h0001_0005);
    wr(12'h848, 32'h0000_0004);
    rd_chk("R3 read via set addr", 12'h844, 32'h0001_0001);
    rd_chk("R3 mask read", 12'h84C, 32'h0);
  endtask

  task automatic t_split;
    rd_chk("R4 both halves", 12'h870, 32'h0000_0300);
    wr(12'h84C, 32'h0000_FFFF);
    rd_chk("R4 tx half masked", 12'h870, 32'h0000_0100);
    wr(12'h84C, 32'hFFFF_0000);
    rd_chk("R4 rx half masked", 12'h870, 32'h0000_0200);
    wr(12'h848, 32'hFFFF_FFFF);
    wr(12'h84C, 32'h0);
    rd_chk("R4 cleared", 12'h870, 32'h0);
  endtask

  task automatic t_dma;
    wr(12'h85C, 32'h0);
    wr(12'h854, 32'h8000_0000);
    rd_chk("R5 dma summary", 12'h870, 32'h0100_0000);
    wr(12'h85C, 32'h8000_0000);
    rd_chk("R5 dma masked", 12'h870, 32'h0);
    wr(12'h858, 32'hFFFF_FFFF);
    rd_chk("R5 dma pend cleared", 12'h850, 32'h0);
  endtask

  task automatic t_immune;
    wr(12'h874, 32'h0100_0301);
    rd_chk("R6 set ignores summary bits", 12'h870, 32'h0000_0001);
    wr(12'h85C, 32'h0);
    wr(12'h854, 32'h1);
    wr(12'h878, 32'hFFFF_FFFF);
    rd_chk("R6 clear leaves dma summary", 12'h870, 32'h0100_0000);
    wr(12'h858, 32'h1);
    wr(12'h874, 32'h0000_000A);
    wr(12'h878, 32'h0000_0002);
    rd_chk("R2 top set/clear", 12'h870, 32'h0000_0008);
  endtask

  task automatic t_polarity;
    // pending 0x8, mask all, polarity 0
    @(negedge clk);
    chk("R7 pol0 all masked", {31'd0, irq_o}, 32'd1);
    wr(12'h87C, 32'hFFFF_FFF7);
    chk("R8 not yet updated", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    chk("R7 pol0 unmasked pending", {31'd0, irq_o}, 32'd0);
    wr(12'h83C, 32'h0002_0000);
    @(negedge clk);
    chk("R7 pol1 unmasked pending", {31'd0, irq_o}, 32'd1);
    wr(12'h878, 32'h0000_0008);
    chk("R8 holds one edge", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    chk("R7 pol1 nothing pending", {31'd0, irq_o}, 32'd0);
    wr(12'h87C, 32'h0);
  endtask

  task automatic t_event;
    @(negedge clk); ev_valid = 1; ev_idx = 5'd3; ev_level = 1;
    @(negedge clk); ev_valid = 0;
    rd_chk("R9 event set", 12'h870, 32'h0000_0008);
    @(negedge clk); ev_valid = 1; ev_idx = 5'd3; ev_level = 0;
    @(negedge clk); ev_valid = 0;
    rd_chk("R9 event clear", 12'h870, 32'h0);
    @(negedge clk); ev_valid = 1; ev_idx = 5'd24; ev_level = 1;
    @(negedge clk); ev_valid = 0;
    rd_chk("R6 event on summary bit ignored", 12'h870, 32'h0);
    // event and clear in same cycle: event wins
    @(negedge clk); bus_wr = 1; bus_addr = 12'h878; bus_wdata = 32'h20;
    ev_valid = 1; ev_idx = 5'd5; ev_level = 1;
    @(negedge clk); bus_wr = 0; ev_valid = 0;
    rd_chk("R9 event beats clear", 12'h870, 32'h0000_0020);
    wr(12'h878, 32'h20);
  endtask

  task automatic t_vbus;
    @(negedge clk); vbus_valid = 1;
    @(negedge clk);
    rd_chk("R10 rising vbus", 12'h870, 32'h0000_8000);
    wr(12'h878, 32'h0000_8000);
    repeat (3) @(negedge clk);
    rd_chk("R10 steady no retrigger", 12'h870, 32'h0);
    @(negedge clk); vbus_valid = 0; bus_wr = 1; bus_addr = 12'h878; bus_wdata = 32'h8000;
    @(negedge clk); bus_wr = 0;
    rd_chk("R10 falling beats clear", 12'h870, 32'h0000_8000);
  endtask

  task automatic t_cfg;
    wr(12'h83C, 32'h1234_5678);
    rd_chk("R11 cfg readback", 12'h83C, 32'h1234_5678);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_group();
    t_split();
    t_dma();
    t_immune();
    t_polarity();
    t_event();
    t_vbus();
    t_cfg();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule